// File: doc/BRIEF.md
# Indirect Table Access Controller

This block is a register front end for reaching wide internal tables through a narrow 32-bit register port. Software sees four registers: one command register and three 32-bit data registers. A command names a table with a two-bit selector and a row with an index. It also carries a direction flag and an execute bit. The engine then runs the access against per-table RAM over a fixed number of cycles. It clears the execute bit when the access is done, so software can poll that bit.

A table row may be wider than one register. It is spread right-aligned across the data registers. Row bit 0 is bit 0 of the last data register, and the row grows toward data register 0. A table whose rows fit in fewer than three registers uses only the highest-numbered registers. Up to four tables are supported, and each has its own depth and width. For a hash-bucket table, software forms the index as the bucket number shifted left by two, with the slot number (0 to 3) in the two low bits.

To write a row, software first fills the data registers and then issues a write command. To read a row, software issues a read command, polls until execute is clear, and then reads the data registers.

Top module: `tblx_ctrl`

## Requirements
- R1: Register address 0 is the command register and addresses 1, 2 and 3 are data registers 0, 1 and 2. In the command word, bit 16 is execute, bit 15 is the direction flag, bits 14:13 select the table and bits 12:0 hold the row index. After reset, every register reads as zero.
- R2: A direction flag of 1 requests a read and a flag of 0 requests a write.
- R3: When a command is written with execute set while the engine is idle, the execute bit reads 1 in each of the three cycles after the write edge. It reads 0 from the fourth cycle on.
- R4: On a read of a table of width W, the row lands in the top ceil(W/32) data registers. Row bit 0 goes to bit 0 of data register 2. Register bits above the row width read as zero.
- R5: On a read, the data registers that the selected table does not use keep their previous values.
- R6: A write stores the low W bits of the 96-bit value formed by data registers 0, 1 and 2 (register 0 most significant) into the row. The store happens on the clock edge on which execute clears.
- R7: A command-register write made while execute is set is ignored. It changes neither the command fields nor any table.
- R8: A data-register write made while execute is set is ignored.
- R9: An index at or beyond the selected table's depth leaves every table unchanged. A read at such an index returns zero in the data registers that table uses.
- R10: The four slots of one hash bucket (index = bucket*4 + slot) are four separate rows, each stored and returned independently.
- R11: A read result is present in the data registers one cycle before execute clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 2 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 2 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |

## Verification
The command is taken on the edge where it is written. Execute is then due high at the three following mid-cycle samples and low at the fourth. The bench samples execute at exactly those four points for every command. For a read, data register 2 is compared at the third sample, while execute is still high, to show that the result arrives one cycle before execute clears. All other expected register values are queued when a command is issued. They are compared only after the fourth sample, and stimulus that is meant to be ignored is applied in the first and second busy cycles.

// File: rtl/tblx_pkg.sv
package tblx_pkg;
  localparam int NTBL   = 4;
  localparam int DWORDS = 3;
  localparam int XW     = 32;
  localparam int FLATW  = DWORDS * XW;
  localparam int IDXW   = 13;
  localparam int EXEC_BIT = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_LOAD, ST_FINISH} eng_state_t;

  // 16-bit command payload: direction at 15, selector at 14:13, index at 12:0
  typedef struct packed {
    logic            is_read;
    logic [1:0]      sel;
    logic [IDXW-1:0] idx;
  } cmd_t;

  function automatic cmd_t cmd_unpack(input logic [EXEC_BIT-1:0] w);
    cmd_t c;
    c.is_read = w[15];
    c.sel     = w[14:13];
    c.idx     = w[IDXW-1:0];
    return c;
  endfunction

  function automatic logic [XW-1:0] cmd_pack(input logic busy, input cmd_t c);
    return {15'd0, busy, c};
  endfunction

  function automatic int words_of(input int width);
    return (width + XW - 1) / XW;
  endfunction
endpackage

// File: rtl/tblx_table_ram.sv
module tblx_table_ram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 87,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wrow,
  output logic [WIDTH-1:0] rrow
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wrow;
    rrow <= mem[addr];
  end
endmodule

// File: rtl/tblx_engine.sv
module tblx_engine
  import tblx_pkg::*;
#(
  parameter logic [NTBL-1:0][15:0] TBL_DEPTHS = {16'd8, 16'd16, 16'd32, 16'd64}
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_wr,
  input  logic [EXEC_BIT:0]   cmd_wdata,
  output logic                busy,
  output logic                cmd_accept,
  output logic                rd_load,
  output logic                wr_commit,
  output logic                hit,
  output cmd_t                cmd_q
);
  eng_state_t state;
  cmd_t       cmd_in;

  assign cmd_in     = cmd_unpack(cmd_wdata[EXEC_BIT-1:0]);
  assign busy       = (state != ST_IDLE);
  assign cmd_accept = cmd_wr && !busy && cmd_wdata[EXEC_BIT];
  assign rd_load    = (state == ST_LOAD) && cmd_q.is_read;
  assign wr_commit  = (state == ST_FINISH) && !cmd_q.is_read && hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cmd_q <= '0;
      hit   <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (cmd_wr) cmd_q <= cmd_in;
          if (cmd_accept) begin
            state <= ST_FETCH;
            hit   <= ({3'b000, cmd_in.idx} < TBL_DEPTHS[cmd_in.sel]);
          end
        end
        ST_FETCH:  state <= ST_LOAD;
        ST_LOAD:   state <= ST_FINISH;
        ST_FINISH: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tblx_data_bank.sv
module tblx_data_bank
  import tblx_pkg::*;
#(
  parameter logic [NTBL-1:0][15:0] TBL_WIDTHS = {16'd40, 16'd32, 16'd64, 16'd87}
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_we,
  input  logic [1:0]       sw_slot,
  input  logic [XW-1:0]    sw_wdata,
  input  logic             busy,
  input  logic             rd_load,
  input  logic             hit,
  input  logic [1:0]       sel,
  input  logic [FLATW-1:0] row_in,
  output logic [FLATW-1:0] data_flat
);
  logic [XW-1:0] dreg [DWORDS];
  int            nwords;

  always_comb nwords = words_of(int'(TBL_WIDTHS[sel]));

  // register 0 is the most significant word of the flat view
  assign data_flat = {dreg[0], dreg[1], dreg[2]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DWORDS; k++) dreg[k] <= '0;
    end else if (rd_load) begin
      for (int j = 0; j < DWORDS; j++)
        if (j < nwords)
          dreg[DWORDS-1-j] <= hit ? row_in[XW*j +: XW] : '0;
    end else if (sw_we && !busy && (sw_slot < 2'(DWORDS))) begin
      dreg[sw_slot] <= sw_wdata;
    end
  end
endmodule

// File: rtl/tblx_ctrl.sv
module tblx_ctrl
  import tblx_pkg::*;
#(
  parameter logic [NTBL-1:0][15:0] TBL_DEPTHS = {16'd8, 16'd16, 16'd32, 16'd64},
  parameter logic [NTBL-1:0][15:0] TBL_WIDTHS = {16'd40, 16'd32, 16'd64, 16'd87}
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [1:0]    reg_waddr,
  input  logic [31:0]   reg_wdata,
  input  logic [1:0]    reg_raddr,
  output logic [31:0]   reg_rdata
);
  logic             busy, cmd_accept, rd_load, wr_commit, hit;
  cmd_t             cmd_q;
  logic [FLATW-1:0] data_flat;
  logic [FLATW-1:0] rows_wide [NTBL];
  logic [FLATW-1:0] row_sel;
  logic             cmd_wr, data_we;
  logic [1:0]       data_slot;

  assign cmd_wr    = reg_we && (reg_waddr == 2'd0);
  assign data_we   = reg_we && (reg_waddr != 2'd0);
  assign data_slot = reg_waddr - 2'd1;

  tblx_engine #(.TBL_DEPTHS(TBL_DEPTHS)) u_eng (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(reg_wdata[EXEC_BIT:0]),
    .busy(busy), .cmd_accept(cmd_accept), .rd_load(rd_load),
    .wr_commit(wr_commit), .hit(hit), .cmd_q(cmd_q)
  );

  generate
    for (genvar k = 0; k < NTBL; k++) begin : g_tbl
      localparam int W  = int'(TBL_WIDTHS[k]);
      localparam int D  = int'(TBL_DEPTHS[k]);
      localparam int AW = (D > 1) ? $clog2(D) : 1;
      logic [W-1:0] rrow;
      logic         we_k;

      assign we_k = wr_commit && (cmd_q.sel == 2'(k));

      tblx_table_ram #(.DEPTH(D), .WIDTH(W)) u_ram (
        .clk(clk), .addr(cmd_q.idx[AW-1:0]), .we(we_k),
        .wrow(data_flat[W-1:0]), .rrow(rrow)
      );

      always_comb begin
        rows_wide[k]        = '0;
        rows_wide[k][W-1:0] = rrow;
      end
    end
  endgenerate

  assign row_sel = rows_wide[cmd_q.sel];

  tblx_data_bank #(.TBL_WIDTHS(TBL_WIDTHS)) u_bank (
    .clk(clk), .rst_n(rst_n), .sw_we(data_we), .sw_slot(data_slot),
    .sw_wdata(reg_wdata), .busy(busy), .rd_load(rd_load), .hit(hit),
    .sel(cmd_q.sel), .row_in(row_sel), .data_flat(data_flat)
  );

  always_comb begin
    unique case (reg_raddr)
      2'd0:    reg_rdata = cmd_pack(busy, cmd_q);
      2'd1:    reg_rdata = data_flat[95:64];
      2'd2:    reg_rdata = data_flat[63:32];
      default: reg_rdata = data_flat[31:0];
    endcase
  end
endmodule

// File: rtl/tblx_chk.sv
module tblx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        cmd_accept,
  input logic        rd_load,
  input logic        wr_commit,
  input logic [95:0] data_flat,
  input logic [15:0] cmd_fields
);
  // R3
  exec_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);
  // R3
  exec_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> busy ##1 busy ##1 !busy);
  // R8
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !rd_load) |=> $stable(data_flat));
  // R7
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cmd_fields));
  // R11
  load_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load |=> busy ##1 !busy);
  // R6
  commit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !busy);
endmodule

bind tblx_ctrl tblx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cmd_accept(cmd_accept),
  .rd_load(rd_load), .wr_commit(wr_commit), .data_flat(data_flat),
  .cmd_fields(cmd_q)
);

// File: tb/tb_tblx_ctrl.sv
module tb_tblx_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_waddr = '0;
  logic [31:0] reg_wdata = '0;
  logic [1:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;

  int errors = 0;
  int checks = 0;

  int bw [4] = '{87, 64, 32, 40};
  int bd [4] = '{64, 32, 16, 8};
  logic [95:0] model [4][64];
  logic [31:0] sh [3];

  typedef struct {int addr; logic [31:0] val; string req;} exp_t;
  exp_t sbq [$];

  always #4 clk = ~clk;

  tblx_ctrl dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
                 .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata));

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic peek(input int a, output logic [31:0] v);
    reg_raddr = 2'(a);
    #1 v = reg_rdata;
  endtask

  task automatic wr_reg(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic set_data(input logic [31:0] d0, input logic [31:0] d1, input logic [31:0] d2);
    wr_reg(1, d0); wr_reg(2, d1); wr_reg(3, d2);
    sh[0] = d0; sh[1] = d1; sh[2] = d2;
  endtask

  function automatic logic [95:0] wmask(input int w);
    return (96'd1 << w) - 96'd1;
  endfunction

  // expected register image after a read (R4, R5, R9)
  task automatic model_read(input int t, input int idx);
    int nw = (bw[t] + 31) / 32;
    for (int j = 0; j < nw; j++)
      sh[2-j] = (idx < bd[t]) ? model[t][idx][32*j +: 32] : 32'd0;
  endtask

  task automatic model_write(input int t, input int idx);
    if (idx < bd[t]) model[t][idx] = {sh[0], sh[1], sh[2]} & wmask(bw[t]);
  endtask

  // issue a command, check the execute window, queue the expected data registers
  task automatic run_cmd(input bit rd, input int t, input int idx, input string req);
    logic [31:0] v;
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 2'd0;
    reg_wdata = {15'd0, 1'b1, rd, 2'(t), 13'(idx)};
    if (rd) model_read(t, idx); else model_write(t, idx);
    @(negedge clk); reg_we = 1'b0;
    peek(0, v); chk({31'd0, v[16]}, 32'd1, "R3 exec cycle1");
    @(negedge clk); peek(0, v); chk({31'd0, v[16]}, 32'd1, "R3 exec cycle2");
    @(negedge clk); peek(0, v); chk({31'd0, v[16]}, 32'd1, "R3 exec cycle3");
    if (rd) begin peek(3, v); chk(v, sh[2], "R11 data before clear"); end
    @(negedge clk); peek(0, v); chk({31'd0, v[16]}, 32'd0, "R3 exec cleared");
    for (int k = 0; k < 3; k++) sbq.push_back('{k + 1, sh[k], req});
  endtask

  // monitor: pops queued expectations and compares against the register port
  task automatic drain();
    logic [31:0] v;
    while (sbq.size() > 0) begin
      exp_t e = sbq.pop_front();
      @(negedge clk);
      peek(e.addr, v);
      chk(v, e.val, e.req);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 3; k++) sh[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 4; a++) begin peek(a, v); chk(v, 32'd0, "R1 reset value"); end

    // R10 / R2 / R4: four slots of bucket 5 in the 87-bit table
    for (int s = 0; s < 4; s++) begin
      set_data(32'hFFFF_F000 | 32'(s), 32'h1234_5670 + 32'(s), 32'hA5A5_0000 | 32'(s << 4));
      run_cmd(1'b0, 0, (5 << 2) | s, "R2 write");
      sbq.delete();
    end
    for (int s = 3; s >= 0; s--) begin
      set_data(32'h0, 32'h0, 32'h0);
      run_cmd(1'b1, 0, (5 << 2) | s, "R10 R4 bucket slot readback");
      drain();
    end

    // R4: 40-bit table, upper bits of register 1 read as zero; R5 register 0 untouched
    set_data(32'h0, 32'hFFFF_FF77, 32'h89AB_CDEF);
    run_cmd(1'b0, 3, 4, "R6 write t3"); sbq.delete();
    set_data(32'h5555_AAAA, 32'h0, 32'h0);
    run_cmd(1'b1, 3, 4, "R4 R5 t3 read"); drain();

    // R5: 64-bit table leaves register 0 alone
    set_data(32'h0, 32'h0BAD_F00D, 32'h1357_9BDF);
    run_cmd(1'b0, 1, 7, "R6 write t1"); sbq.delete();
    set_data(32'hDEAD_BEEF, 32'h0, 32'h0);
    run_cmd(1'b1, 1, 7, "R5 t1 read keeps reg0"); drain();

    // seed table 2 row 3
    set_data(32'h0, 32'h0, 32'hCAFE_0003);
    run_cmd(1'b0, 2, 3, "R6 write t2"); sbq.delete();

    // R7 / R8: writes during busy are ignored
    set_data(32'h1111_2222, 32'h0, 32'h0);
    @(negedge clk);
    reg_we = 1'b1; reg_waddr = 2'd0; reg_wdata = {15'd0, 1'b1, 1'b1, 2'd1, 13'd7};
    @(negedge clk);
    reg_waddr = 2'd1; reg_wdata = 32'h0BAD_0BAD;
    @(negedge clk);
    reg_waddr = 2'd0; reg_wdata = {15'd0, 1'b1, 1'b0, 2'd2, 13'd3};
    @(negedge clk);
    reg_we = 1'b0;
    @(negedge clk);
    peek(0, v); chk(v, {15'd0, 1'b0, 1'b1, 2'd1, 13'd7}, "R7 command fields unchanged");
    peek(1, v); chk(v, 32'h1111_2222, "R8 data reg0 unchanged");
    model_read(1, 7);
    peek(3, v); chk(v, sh[2], "R2 read result reg2");

    // R9: out-of-range read and write
    set_data(32'h7777_0000, 32'h6666_0000, 32'hFFFF_FFFF);
    run_cmd(1'b1, 2, 20, "R9 out-of-range read"); drain();
    set_data(32'h0, 32'h0000_0011, 32'h2222_3333);
    run_cmd(1'b0, 3, 12, "R9 out-of-range write"); sbq.delete();
    run_cmd(1'b1, 3, 4, "R9 alias row unchanged"); drain();

    // R7: ignored write command did not touch table 2 row 3
    run_cmd(1'b1, 2, 3, "R7 ignored write left row"); drain();

    finish_run();
  end
endmodule